// File: doc/BRIEF.md
# Carry-Save Systolic FIR Tap

This block is one stage of a systolic FIR filter whose coefficients can be changed at run time. It adds two coefficient products to a running partial sum. The sum enters and leaves in redundant form, as a save word and a carry word. Carry propagation is deferred, so the stage holds no carry-propagate adder. The filter's final adder resolves the two words once, after the last stage.

In each enabled cycle the stage does three things. It multiplies the current sample by the first coefficient. It multiplies the sample from the previous enabled cycle by the second coefficient. Each multiplier leaves its product as a pair of words. The four product words and the incoming save and carry words are then reduced to two words. The product sum is scaled down by a fixed number of fraction bits, so the outgoing words keep the width of the incoming ones. Because of this, identical stages can be chained without limit. The sample passes on to the next stage through two delay registers.

Top module: `cs_fir_tap`

## Requirements
- R1: While `rst_n` is low, `sum_s_out`, `sum_c_out` and `smp_out` are all zero, and they are zero in the first cycle after reset ends.
- R2: After an enabled clock edge, (`sum_s_out` + `sum_c_out`) mod 2^AW_W equals (`sum_s_in` + `sum_c_in` + floor((`smp_in`·`coef_a` + s1·`coef_b`) / 2^FRAC_W)) mod 2^AW_W. All values are taken at that edge. Samples and coefficients are signed two's complement, and the partial-sum words are unsigned.
- R3: s1 in R2 is the value of `smp_in` at the previous enabled edge, or zero if there has been no enabled edge since reset.
- R4: `smp_out` is the value `smp_in` had two enabled edges earlier, and zero until two enabled edges have occurred.
- R5: When `en` is low at an edge, none of the three outputs changes, whatever the data inputs are. The sample used as s1 is also kept.
- R6: The truncation is an exact floor of the full-precision sum of both products. It rounds toward minus infinity, also for negative sums. The incoming save and carry words are added unscaled.
- R7: The partial-sum arithmetic wraps modulo 2^AW_W, so a result above the word range comes back around with no saturation.
- R8: Operand extremes, including the most negative sample times the most negative coefficient, give the exact product in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for every register of the stage |
| smp_in | input | SMP_W | Signed input sample |
| coef_a | input | COEF_W | Signed coefficient applied to the current sample |
| coef_b | input | COEF_W | Signed coefficient applied to the previous sample |
| sum_s_in | input | AW_W | Incoming partial sum, save word |
| sum_c_in | input | AW_W | Incoming partial sum, carry word |
| sum_s_out | output | AW_W | Outgoing partial sum, save word (registered) |
| sum_c_out | output | AW_W | Outgoing partial sum, carry word (registered) |
| smp_out | output | SMP_W | Sample forwarded to the next stage after two enabled cycles |

## Verification
The save and carry words may change freely from one build to another. Only their sum is observable, so every check resolves the pair with an ordinary adder one edge after the inputs were applied. A wrong product, a dropped low-column carry or a mis-weighted injected bit changes that resolved sum on the very next edge. A stale or wrongly enabled delayed sample shows up one edge later, as a sum error that involves the second coefficient. It also shows up two edges later, as a wrong forwarded sample. Sweeping every sample and coefficient pair of a narrow build exercises every partial-product row, including the negative-weight top row.

// File: rtl/cs_fir_pkg.sv
package cs_fir_pkg;
   // operands entering the reduction stage: two product pairs plus save and carry
   localparam int unsigned CS_OPERANDS = 6;
   // width needed by the low-column adder that realises the truncation
   function automatic int unsigned low_col_width(input int unsigned frac_w);
      return frac_w + 2;
   endfunction
endpackage

// File: rtl/cs_fir_csa.sv
module cs_fir_csa #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] op_d,
   input  logic         lsb_in,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);
   logic [W-1:0] maj;
   always_comb begin
      sum_o = op_a ^ op_b ^ op_d;
      maj   = (op_a & op_b) | (op_a & op_d) | (op_b & op_d);
      cry_o = {maj[W-2:0], lsb_in};
   end
endmodule

// File: rtl/cs_fir_mult.sv
module cs_fir_mult #(
   parameter int unsigned SMP_W  = 8,
   parameter int unsigned COEF_W = 8,
   parameter int unsigned IW     = 20
) (
   input  logic [SMP_W-1:0]  smp,
   input  logic [COEF_W-1:0] coef,
   output logic [IW-1:0]     prod_s,
   output logic [IW-1:0]     prod_c
);
   logic [IW-1:0] sx;
   logic [IW-1:0] s_ch [0:COEF_W];
   logic [IW-1:0] c_ch [0:COEF_W];

   assign sx      = {{(IW-SMP_W){smp[SMP_W-1]}}, smp};
   assign s_ch[0] = '0;
   // the +1 of the negated top row rides in the first carry word
   assign c_ch[0] = {{(IW-1){1'b0}}, coef[COEF_W-1]};

   for (genvar r = 0; r < COEF_W; r++) begin : g_row
      logic [IW-1:0] pp;
      if (r == COEF_W - 1) begin : g_neg
         assign pp = coef[r] ? ~(sx << r) : '0;
      end else begin : g_pos
         assign pp = coef[r] ? (sx << r) : '0;
      end
      cs_fir_csa #(.W(IW)) u_csa (
         .op_a(s_ch[r]), .op_b(c_ch[r]), .op_d(pp), .lsb_in(1'b0),
         .sum_o(s_ch[r+1]), .cry_o(c_ch[r+1])
      );
   end

   assign prod_s = s_ch[COEF_W];
   assign prod_c = c_ch[COEF_W];
endmodule

// File: rtl/cs_fir_comp62.sv
module cs_fir_comp62
   import cs_fir_pkg::*;
#(
   parameter int unsigned AW_W   = 16,
   parameter int unsigned FRAC_W = 4,
   parameter int unsigned IW     = AW_W + FRAC_W
) (
   input  logic [AW_W-1:0] ps_in,
   input  logic [AW_W-1:0] pc_in,
   input  logic [IW-1:0]   pa_s,
   input  logic [IW-1:0]   pa_c,
   input  logic [IW-1:0]   pb_s,
   input  logic [IW-1:0]   pb_c,
   output logic [AW_W-1:0] sum_s,
   output logic [AW_W-1:0] sum_c
);
   logic [1:0]      k;
   logic [AW_W-1:0] ua_s, ua_c, ub_s, ub_c;

   if (FRAC_W > 0) begin : g_trunc
      localparam int unsigned LW = low_col_width(FRAC_W);
      logic [LW-1:0] low;
      assign low  = LW'(pa_s[FRAC_W-1:0]) + LW'(pa_c[FRAC_W-1:0])
                  + LW'(pb_s[FRAC_W-1:0]) + LW'(pb_c[FRAC_W-1:0]);
      assign k    = low[LW-1:FRAC_W];
      assign ua_s = pa_s[IW-1:FRAC_W];
      assign ua_c = pa_c[IW-1:FRAC_W];
      assign ub_s = pb_s[IW-1:FRAC_W];
      assign ub_c = pb_c[IW-1:FRAC_W];
   end else begin : g_full
      assign k    = 2'b00;
      assign ua_s = pa_s;
      assign ua_c = pa_c;
      assign ub_s = pb_s;
      assign ub_c = pb_c;
   end

   logic [AW_W-1:0] s1, c1, s2, c2, s3, c3;
   // low-column carry k (0..3) enters through free carry LSBs: weight 1 + 2 * 1
   cs_fir_csa #(.W(AW_W)) u_l1a (.op_a(ps_in), .op_b(pc_in), .op_d(ua_s),
      .lsb_in(k[0]), .sum_o(s1), .cry_o(c1));
   cs_fir_csa #(.W(AW_W)) u_l1b (.op_a(ua_c), .op_b(ub_s), .op_d(ub_c),
      .lsb_in(k[1]), .sum_o(s2), .cry_o(c2));
   cs_fir_csa #(.W(AW_W)) u_l2  (.op_a(s1), .op_b(c1), .op_d(s2),
      .lsb_in(k[1]), .sum_o(s3), .cry_o(c3));
   cs_fir_csa #(.W(AW_W)) u_l3  (.op_a(s3), .op_b(c3), .op_d(c2),
      .lsb_in(1'b0), .sum_o(sum_s), .cry_o(sum_c));
endmodule

// File: rtl/cs_fir_tap.sv
module cs_fir_tap
   import cs_fir_pkg::*;
#(
   parameter int unsigned SMP_W  = 8,
   parameter int unsigned COEF_W = 8,
   parameter int unsigned AW_W   = 16,
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SMP_W-1:0]  smp_in,
   input  logic [COEF_W-1:0] coef_a,
   input  logic [COEF_W-1:0] coef_b,
   input  logic [AW_W-1:0]   sum_s_in,
   input  logic [AW_W-1:0]   sum_c_in,
   output logic [AW_W-1:0]   sum_s_out,
   output logic [AW_W-1:0]   sum_c_out,
   output logic [SMP_W-1:0]  smp_out
);
   localparam int unsigned IW    = AW_W + FRAC_W;
   localparam int unsigned LANES = (CS_OPERANDS - 2) / 2;

   if (SMP_W < 2 || COEF_W < 2) begin : g_bad_w
      $error("cs_fir_tap: sample and coefficient need at least 2 bits");
   end
   if (IW <= SMP_W) begin : g_bad_iw
      $error("cs_fir_tap: AW_W + FRAC_W must exceed SMP_W");
   end

   logic [SMP_W-1:0] smp_d1;
   logic [SMP_W-1:0] lane_smp  [LANES];
   logic [COEF_W-1:0] lane_cf  [LANES];
   logic [IW-1:0]    lane_s    [LANES];
   logic [IW-1:0]    lane_c    [LANES];
   logic [AW_W-1:0]  nxt_s, nxt_c;

   assign lane_smp[0] = smp_in;
   assign lane_cf[0]  = coef_a;
   assign lane_smp[1] = smp_d1;
   assign lane_cf[1]  = coef_b;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      cs_fir_mult #(.SMP_W(SMP_W), .COEF_W(COEF_W), .IW(IW)) u_mult (
         .smp(lane_smp[l]), .coef(lane_cf[l]),
         .prod_s(lane_s[l]), .prod_c(lane_c[l])
      );
   end

   cs_fir_comp62 #(.AW_W(AW_W), .FRAC_W(FRAC_W), .IW(IW)) u_comp (
      .ps_in(sum_s_in), .pc_in(sum_c_in),
      .pa_s(lane_s[0]), .pa_c(lane_c[0]),
      .pb_s(lane_s[1]), .pb_c(lane_c[1]),
      .sum_s(nxt_s), .sum_c(nxt_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_d1    <= '0;
         smp_out   <= '0;
         sum_s_out <= '0;
         sum_c_out <= '0;
      end else if (en) begin
         smp_d1    <= smp_in;
         smp_out   <= smp_d1;
         sum_s_out <= nxt_s;
         sum_c_out <= nxt_c;
      end
   end
endmodule

// File: rtl/cs_fir_tap_chk.sv
module cs_fir_tap_chk #(
   parameter int unsigned SMP_W  = 8,
   parameter int unsigned COEF_W = 8,
   parameter int unsigned AW_W   = 16,
   parameter int unsigned FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [SMP_W-1:0]  smp_in,
   input logic [COEF_W-1:0] coef_a,
   input logic [COEF_W-1:0] coef_b,
   input logic [AW_W-1:0]   sum_s_in,
   input logic [AW_W-1:0]   sum_c_in,
   input logic [AW_W-1:0]   sum_s_out,
   input logic [AW_W-1:0]   sum_c_out,
   input logic [SMP_W-1:0]  smp_out
);
   function automatic logic [AW_W-1:0] ref_sum(
      input logic [AW_W-1:0] s, input logic [AW_W-1:0] c,
      input logic signed [SMP_W-1:0] x0, input logic signed [SMP_W-1:0] x1,
      input logic signed [COEF_W-1:0] a, input logic signed [COEF_W-1:0] b);
      longint p;
      p = longint'(x0) * longint'(a) + longint'(x1) * longint'(b);
      p = p >>> FRAC_W;
      return AW_W'(longint'(s) + longint'(c) + p);
   endfunction

   logic [AW_W-1:0] res;
   assign res = sum_s_out + sum_c_out;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (sum_s_out == '0 && sum_c_out == '0 && smp_out == '0)); // R1

   AST_SUM_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $past(rst_n)) |=>
      res == ref_sum($past(sum_s_in), $past(sum_c_in), $past(smp_in),
                     $past(smp_in, 2), $past(coef_a), $past(coef_b))); // R2

   AST_FWD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $past(rst_n)) |=> smp_out == $past(smp_in, 2)); // R4

   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(sum_s_out) && $stable(sum_c_out) && $stable(smp_out))); // R5
endmodule

bind cs_fir_tap cs_fir_tap_chk #(
   .SMP_W(SMP_W), .COEF_W(COEF_W), .AW_W(AW_W), .FRAC_W(FRAC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .smp_in(smp_in), .coef_a(coef_a),
   .coef_b(coef_b), .sum_s_in(sum_s_in), .sum_c_in(sum_c_in),
   .sum_s_out(sum_s_out), .sum_c_out(sum_c_out), .smp_out(smp_out)
);

// File: tb/cs_fir_tap_bench.sv
module cs_fir_tap_bench;
   localparam int CLK_PER = 10;
   localparam int XW = 4;
   localparam int CW = 4;
   localparam int AW = 10;
   localparam int FR = 2;
   localparam int MASK = (1 << AW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [XW-1:0] smp_in = '0;
   logic [CW-1:0] coef_a = '0, coef_b = '0;
   logic [AW-1:0] s_in = '0, c_in = '0;
   logic [AW-1:0] s_out, c_out;
   logic [XW-1:0] smp_out;

   int total = 0, bad = 0;
   int h1 = 0, h2 = 0;   // samples accepted one and two enabled edges back

   always #(CLK_PER/2) clk = ~clk;

   cs_fir_tap #(.SMP_W(XW), .COEF_W(CW), .AW_W(AW), .FRAC_W(FR)) u_cs_fir_tap (
      .clk(clk), .rst_n(rst_n), .en(en), .smp_in(smp_in), .coef_a(coef_a),
      .coef_b(coef_b), .sum_s_in(s_in), .sum_c_in(c_in),
      .sum_s_out(s_out), .sum_c_out(c_out), .smp_out(smp_out));

   function automatic int sx(input int v, input int w);
      v = v & ((1 << w) - 1);
      return (v >= (1 << (w-1))) ? v - (1 << w) : v;
   endfunction

   function automatic int model(input int s, input int c, input int x0, input int x1,
                                input int a, input int b);
      int p;
      p = x0 * a + x1 * b;
      p = p >>> FR;
      return (s + c + p) & MASK;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // apply one enabled edge, check sum (R2/R3) and forwarded sample (R4)
   task automatic step(input string req, input int x, input int a, input int b,
                       input int s, input int c);
      int e;
      smp_in = XW'(x); coef_a = CW'(a); coef_b = CW'(b);
      s_in = AW'(s); c_in = AW'(c); en = 1'b1;
      e = model(s & MASK, c & MASK, sx(x, XW), h1, sx(a, CW), sx(b, CW));
      @(posedge clk);
      h2 = h1; h1 = sx(x, XW);
      @(negedge clk);
      chk(req, int'((s_out + c_out) & AW'(MASK)), e);
      chk("R4", sx(int'(smp_out), XW), h2);
   endtask

   initial begin : watchdog
      #(CLK_PER * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int hs, hc, hx;
      repeat (3) @(negedge clk);
      chk("R1", int'(s_out), 0); chk("R1", int'(c_out), 0); chk("R1", int'(smp_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(s_out) + int'(c_out) + int'(smp_out), 0);

      // R3: first enabled edge after reset has a zero delayed sample
      step("R3", 5, 3, 7, 0, 0);
      // exhaustive sample x coefficient sweep (R2, R6 floor on negative sums)
      for (int x = -8; x < 8; x++) begin
         for (int a = -8; a < 8; a++) begin
            step("R2", x, a, (x * 5 + a * 3 + 1), (x * 37 + a * 11) & MASK,
                 (a * 53 - x * 7) & MASK);
         end
      end
      // R6: -1 * 1 has floor(-1/4) = -1, not 0
      step("R6", -1, 1, 0, 100, 0);
      step("R6", 1, 1, 0, 100, 0);
      // R8: most negative times most negative in both lanes
      step("R8", -8, -8, 0, 0, 0);
      step("R8", -8, -8, -8, 0, 0);
      // R7: wraparound of the partial sum
      step("R7", 7, 7, 7, MASK, MASK);

      // R5: en low, changing inputs, outputs frozen and delayed sample kept
      hs = int'(s_out); hc = int'(c_out); hx = int'(smp_out);
      en = 1'b0; smp_in = 4'h3; coef_a = 4'h5; coef_b = 4'h6; s_in = 10'h155; c_in = 10'h0AA;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5", int'(s_out), hs); chk("R5", int'(c_out), hc); chk("R5", int'(smp_out), hx);
      step("R5", 0, 0, 1, 0, 0);   // sum exposes the kept delayed sample (7) times 1
      step("R3", 2, 3, -4, 9, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule